// File: doc/BRIEF.md
# PCM Time Slot Interchanger

This block exchanges the positions of 8-bit PCM samples within a serial time-division frame. A frame holds `SLOTS` time slots of one sample each, and repeats every 125 µs (8000 frames per second). One bit moves per cycle of the bit clock. Incoming bits are gathered into sample words. A slot counter stores each word in a sample store in arrival order. On the way out, a per-slot map entry chooses which stored sample fills each outgoing slot. The chosen word is shifted back onto the serial output.

The sample store has two banks. While one frame is captured into one bank, the previous frame is played from the other bank. Every sample therefore sees exactly one frame of delay, and the samples of a frame never mix with those of another frame. The slot map is loaded through a plain write port. A new entry is held in a shadow copy and goes live only at a frame boundary, so no outgoing frame is ever built from two maps.

Both serial lines run at a fixed bit rate with no valid/ready handshake. A TDM line cannot pause, so every cycle carries one bit and no back-pressure exists at either edge. The frame sync input sets the position of the stream, and `sdo` follows the same bit positions one frame later.

Top module: `tsi_slot_swap`

## Requirements
- R1: While `rst_n` is low, `sdo` is 0. The sample store resets to all zeros, so `sdo` stays 0 until samples from the first frame captured after reset are played out.
- R2: `sdi` is sampled on each rising edge of `clk`, most significant bit first. `fs` is high in the cycle that carries the first (most significant) bit of slot 0. A high `fs` in any cycle restarts bit and slot counting at that bit.
- R3: In the cycle in which `sdi` carries bit b of slot s of frame F+1, `sdo` carries bit b of slot `map[s]` of input frame F. Bit b counts from the MSB. This gives one frame of delay, with banks alternating after the last bit of slot `SLOTS-1`.
- R4: A cycle with `cm_we` high writes `cm_data` into map entry `cm_addr`, and writes with `cm_addr >= SLOTS` are ignored. A write is used from the first frame boundary after it. A write made in the cycle of the last bit of a frame is used only from the boundary after the next one.
- R5: A source slot may appear in any number of map entries. Output slot 0 may take the last input slot of the frame that has just ended, even though that word is completed in the same cycle.
- R6: After reset, every map entry s holds s, so the frame passes through in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs | input | 1 | Frame sync, high with the MSB of slot 0 |
| sdi | input | 1 | Serial PCM input |
| sdo | output | 1 | Serial PCM output, one frame later and reordered |
| cm_we | input | 1 | Map write strobe |
| cm_addr | input | $clog2(SLOTS) | Outgoing slot whose map entry is written |
| cm_data | input | $clog2(SLOTS) | Incoming slot number to place in that outgoing slot |

## Verification
A bank select of the wrong polarity shows at the output within one frame. The whole output frame then carries stale samples or samples from the same frame. A counter that has drifted from the sync shifts or rotates the bits inside a sample on the next slot boundary. A map copied at the wrong moment shows as a single wrong byte in the first frame after the update, or in the frame before it. Output slot 0 of a map that points at the last input slot exposes any missing forwarding of the word completed on the wrap edge.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic bank_e other_bank(bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
  import tsi_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 8,
  parameter int AW       = 3,
  parameter int BW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs,
  output logic [AW-1:0] cur_slot,
  output logic [AW-1:0] next_slot,
  output logic          slot_end,
  output logic          frame_end,
  output bank_e         wr_bank
);
  localparam logic [BW-1:0] BIT_LAST  = BW'(SAMPLE_W - 1);
  localparam logic [AW-1:0] SLOT_LAST = AW'(SLOTS - 1);

  logic [BW-1:0] bit_q;
  logic [BW-1:0] cur_bit;
  logic [AW-1:0] slot_q;

  always_comb begin
    cur_bit   = fs ? '0 : bit_q;
    cur_slot  = fs ? '0 : slot_q;
    slot_end  = (cur_bit == BIT_LAST);
    frame_end = slot_end && (cur_slot == SLOT_LAST);
    next_slot = (cur_slot == SLOT_LAST) ? '0 : cur_slot + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      slot_q  <= '0;
      wr_bank <= BANK_A;
    end else begin
      bit_q  <= slot_end ? '0 : cur_bit + 1'b1;
      slot_q <= slot_end ? next_slot : cur_slot;
      if (frame_end) wr_bank <= other_bank(wr_bank);
    end
  end
endmodule

// File: rtl/tsi_ser2par.sv
module tsi_ser2par #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdi,
  output logic [SAMPLE_W-1:0] word_now
);
  logic [SAMPLE_W-2:0] shreg;

  assign word_now = {shreg, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= word_now[SAMPLE_W-2:0];
  end
endmodule

// File: rtl/tsi_ctrl_map.sv
module tsi_ctrl_map #(
  parameter int SLOTS = 8,
  parameter int AW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cm_we,
  input  logic [AW-1:0]            cm_addr,
  input  logic [AW-1:0]            cm_data,
  input  logic                     frame_end,
  output logic [SLOTS-1:0][AW-1:0] pend_map,
  output logic [SLOTS-1:0][AW-1:0] act_map
);
  localparam logic [AW:0] SLOTS_X = (AW+1)'(SLOTS);

  logic addr_ok;
  assign addr_ok = ({1'b0, cm_addr} < SLOTS_X);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        pend_map[i] <= AW'(i);
        act_map[i]  <= AW'(i);
      end
    end else begin
      if (cm_we && addr_ok) pend_map[cm_addr] <= cm_data;
      if (frame_end)        act_map <= pend_map;
    end
  end
endmodule

// File: rtl/tsi_sample_store.sv
module tsi_sample_store
  import tsi_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int AW       = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bank_e               wr_bank,
  input  logic [AW-1:0]       cur_slot,
  input  logic                slot_end,
  input  logic                frame_end,
  input  logic [SAMPLE_W-1:0] word_now,
  input  logic [AW-1:0]       rd_addr,
  output logic [SAMPLE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [SAMPLE_W-1:0] mem [2][DEPTH];
  logic wb;
  logic rb;

  assign wb = (wr_bank == BANK_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < DEPTH; a++)
          mem[b][a] <= '0;
    end else if (slot_end) begin
      mem[wb][cur_slot] <= word_now;
    end
  end

  always_comb begin
    rb = frame_end ? wb : ~wb;
    if (frame_end && (rd_addr == cur_slot)) rd_word = word_now;
    else                                    rd_word = mem[rb][rd_addr];
  end
endmodule

// File: rtl/tsi_par2ser.sv
module tsi_par2ser #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] load_word,
  output logic                sdo
);
  logic [SAMPLE_W-1:0] osh;

  assign sdo = osh[SAMPLE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    osh <= '0;
    else if (load) osh <= load_word;
    else           osh <= {osh[SAMPLE_W-2:0], 1'b0};
  end
endmodule

// File: rtl/tsi_slot_swap.sv
module tsi_slot_swap
  import tsi_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 8,
  localparam int AW      = $clog2(SLOTS),
  localparam int BW      = $clog2(SAMPLE_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs,
  input  logic          sdi,
  output logic          sdo,
  input  logic          cm_we,
  input  logic [AW-1:0] cm_addr,
  input  logic [AW-1:0] cm_data
);
  logic [AW-1:0]            cur_slot;
  logic [AW-1:0]            next_slot;
  logic                     slot_end;
  logic                     frame_end;
  bank_e                    wr_bank;
  logic [SAMPLE_W-1:0]      word_now;
  logic [SLOTS-1:0][AW-1:0] pend_map;
  logic [SLOTS-1:0][AW-1:0] act_map;
  logic [AW-1:0]            load_addr;
  logic [SAMPLE_W-1:0]      load_word;

  tsi_frame_timer #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .AW(AW), .BW(BW)) u_timer (
    .clk(clk), .rst_n(rst_n), .fs(fs),
    .cur_slot(cur_slot), .next_slot(next_slot),
    .slot_end(slot_end), .frame_end(frame_end), .wr_bank(wr_bank)
  );

  tsi_ser2par #(.SAMPLE_W(SAMPLE_W)) u_s2p (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .word_now(word_now)
  );

  tsi_ctrl_map #(.SLOTS(SLOTS), .AW(AW)) u_map (
    .clk(clk), .rst_n(rst_n), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_data(cm_data), .frame_end(frame_end),
    .pend_map(pend_map), .act_map(act_map)
  );

  // On the wrap edge the map that takes over is the shadow copy.
  assign load_addr = frame_end ? pend_map[next_slot] : act_map[next_slot];

  tsi_sample_store #(.SAMPLE_W(SAMPLE_W), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_bank(wr_bank), .cur_slot(cur_slot),
    .slot_end(slot_end), .frame_end(frame_end), .word_now(word_now),
    .rd_addr(load_addr), .rd_word(load_word)
  );

  tsi_par2ser #(.SAMPLE_W(SAMPLE_W)) u_p2s (
    .clk(clk), .rst_n(rst_n), .load(slot_end), .load_word(load_word), .sdo(sdo)
  );
endmodule

// File: rtl/tsi_slot_swap_chk.sv
module tsi_slot_swap_chk
  import tsi_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int SAMPLE_W = 8,
  parameter int AW       = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fs,
  input logic                     sdo,
  input logic                     slot_end,
  input logic                     frame_end,
  input bank_e                    wr_bank,
  input logic [SLOTS-1:0][AW-1:0] pend_map,
  input logic [SLOTS-1:0][AW-1:0] act_map
);
  int pos;
  int eff;
  logic seen;

  assign eff = fs ? 0 : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= 0;
      seen <= 1'b0;
    end else begin
      if (fs) seen <= 1'b1;
      pos <= (eff == SAMPLE_W - 1) ? 0 : eff + 1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (sdo == 1'b0) else $error("R1 sdo high in reset");
  end

  a_r2_slot_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (seen || fs) |-> (slot_end == (eff == SAMPLE_W - 1)));

  a_r3_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (wr_bank != $past(wr_bank)));

  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(wr_bank));

  a_r4_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(act_map));

  a_r4_map_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (act_map == $past(pend_map)));
endmodule

bind tsi_slot_swap tsi_slot_swap_chk #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs(fs), .sdo(sdo), .slot_end(slot_end),
  .frame_end(frame_end), .wr_bank(wr_bank), .pend_map(pend_map), .act_map(act_map)
);

// File: tb/sim_tsi_slot_swap.sv
module sim_tsi_slot_swap;
  localparam int CLK_P = 10;
  localparam int SLOTS = 8;
  localparam int W     = 8;
  localparam int AW    = 3;
  localparam int FBITS = SLOTS * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0;
  logic sdi = 1'b0;
  logic cm_we = 1'b0;
  logic [AW-1:0] cm_addr = '0;
  logic [AW-1:0] cm_data = '0;
  logic sdo;

  always #(CLK_P/2) clk = ~clk;

  tsi_slot_swap #(.SLOTS(SLOTS), .SAMPLE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .fs(fs), .sdi(sdi), .sdo(sdo),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  int checks = 0;
  int failures = 0;
  bit streaming = 0;
  bit finished = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  int           map_pend[SLOTS];
  int           snap[SLOTS];
  logic [W-1:0] fdata[SLOTS];
  int           sch_addr[FBITS];
  int           sch_data[FBITS];

  task automatic check_byte(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: one byte per outgoing slot, compared against the scoreboard.
  logic [W-1:0] mon_sh = '0;
  int mon_n = 0;
  always @(negedge clk) begin
    #1;
    if (streaming && !finished) begin
      mon_sh = {mon_sh[W-2:0], sdo};
      mon_n++;
      if (mon_n == W) begin
        mon_n = 0;
        if (exp_q.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R3: got %h expected nothing queued", mon_sh);
        end else begin
          check_byte(tag_q.pop_front(), mon_sh, exp_q.pop_front());
        end
      end
    end
  end

  // Driver: one frame, with map writes taken from the schedule.
  task automatic drive_frame(string tag);
    for (int i = 0; i < FBITS; i++) begin
      @(negedge clk);
      fs = (i == 0);
      if (i == 0) streaming = 1;
      sdi = fdata[i / W][W - 1 - (i % W)];
      if (sch_addr[i] >= 0) begin
        cm_we   = 1'b1;
        cm_addr = AW'(sch_addr[i]);
        cm_data = AW'(sch_data[i]);
      end else begin
        cm_we = 1'b0;
      end
      if (i == FBITS - 1)
        for (int s = 0; s < SLOTS; s++) snap[s] = map_pend[s];
      if (sch_addr[i] >= 0) map_pend[sch_addr[i]] = sch_data[i];
    end
    for (int s = 0; s < SLOTS; s++) begin
      exp_q.push_back(fdata[snap[s]]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < FBITS; i++) sch_addr[i] = -1;
  endtask

  task automatic check_bit(string tag);
    checks++;
    if (sdo !== 1'b0) begin
      failures++;
      $display("FAIL %s: got %b expected 0", tag, sdo);
    end
  endtask

  initial begin
    for (int i = 0; i < FBITS; i++) sch_addr[i] = -1;
    for (int s = 0; s < SLOTS; s++) map_pend[s] = s;   // R6 identity after reset

    repeat (3) begin
      @(negedge clk); #1;
      check_bit("R1 in reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (13) begin
      @(negedge clk); #1;
      check_bit("R1 idle after reset");
    end

    // R1: first synchronized frame plays out zeros from the cleared store.
    for (int s = 0; s < SLOTS; s++) begin
      exp_q.push_back('0);
      tag_q.push_back("R1 first frame");
    end

    // R2, R6: sync after an odd idle gap, identity map, MSB first.
    for (int s = 0; s < SLOTS; s++) fdata[s] = W'(8'hA0 + s);
    drive_frame("R2,R6 identity");

    // R4: map reversal written mid-frame, live from the next boundary.
    for (int s = 0; s < SLOTS; s++) begin
      fdata[s] = W'(8'h5C ^ (s * 17));
      sch_addr[3 + s] = s;
      sch_data[3 + s] = SLOTS - 1 - s;
    end
    drive_frame("R4 reversal");

    // R4: a write on the last bit waits one more frame.
    for (int s = 0; s < SLOTS; s++) fdata[s] = W'(s * 29 + 7);
    sch_addr[FBITS-1] = 0;
    sch_data[FBITS-1] = 5;
    drive_frame("R4 last-bit write");

    // R4/R5: broadcast of the last slot to every outgoing slot.
    for (int s = 0; s < SLOTS; s++) begin
      fdata[s] = W'(s * 11 + 8'h33);
      sch_addr[s] = s;
      sch_data[s] = SLOTS - 1;
    end
    drive_frame("R4 broadcast");

    // R5: slot 0 fed from the word completed on the wrap edge.
    for (int s = 0; s < SLOTS; s++) fdata[s] = W'((s * 41 + 5) ^ 8'hC3);
    drive_frame("R5 wrap forward");

    // R3: general permutation.
    for (int s = 0; s < SLOTS; s++) begin
      fdata[s] = W'(s * 37 + 13);
      sch_addr[20 + s] = s;
      sch_data[20 + s] = (3 * s) % SLOTS;
    end
    drive_frame("R3 permutation");

    for (int s = 0; s < SLOTS; s++) fdata[s] = W'(8'hFF - s * 19);
    drive_frame("R3 permutation hold");

    for (int s = 0; s < SLOTS; s++) fdata[s] = '0;
    drive_frame("R3 tail");

    cm_we = 1'b0;
    #2;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL R3 watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule